// File: doc/BRIEF.md
# Two-Bank Feature Hand-Off Buffer

This block sits between a producer that streams one frame's worth of 32-bit feature words and a consumer that processes complete frames. It holds two equal banks of storage. The producer always writes into the bank the controller names, at consecutive word addresses, while the consumer owns the other bank. When a frame ends, the controller marks that bank as held, publishes its number in a filled-bank register, raises a level interrupt and moves the producer to the other bank.

The consumer reacts to the interrupt with a command write that locks the published bank and clears the published number. It then reads the bank through a read port with one cycle of latency, using the byte fill count of the bank to know how much to read. It finishes with a release command that returns the bank to the producer. If the producer's next bank is still held, the controller asserts a throttle output, drops incoming words and sets a sticky overflow flag.

With the default depth each bank holds 1024 words (4 KB), for 8 KB in total.

Top module: `feat_pingpong_ctrl`

## Requirements
- R1: After reset both banks are free and unlocked, the producer targets bank 0, the filled-bank register is invalid, irq, throttle and the overflow flag are 0, and both fill counts read 0.
- R2: Each word accepted from the producer is stored in the target bank at the word address equal to the number of words already in that bank; with rd_en high at one edge, rd_data shows the word at {rd_bank, rd_addr} after that edge.
- R3: A frame completes when prd_eof is sampled high while the target bank is free (a word written in the same cycle belongs to the frame, and prd_eof with no word closes an empty frame) or when the word that makes the bank hold BANK_WORDS words is written; the bank becomes held, the filled-bank register takes valid=1 and that bank number, and prd_bank flips.
- R4: irq equals the filled-bank valid bit; a command write with the clear bit (bit 1) set drops it on the next cycle.
- R5: CSR address 2 and 3 read the byte count (4 x words) of bank 0 and bank 1; a count is kept until that bank is released, which sets it to 0.
- R6: A command write (CSR address 1) with the lock bit (bit 0) locks the bank named by the filled-bank register, only if that register is valid and the bank is held; otherwise it has no effect.
- R7: A command write with the release bit (bit 2) frees the bank given in bit 3 if that bank is locked (held, locked and fill count cleared); for an unlocked bank it has no effect.
- R8: While the target bank is held, throttle is 1, producer words and prd_eof are dropped and any dropped word sets the sticky overflow flag; a command write with bit 4 set clears the flag, unless a word is dropped in the same cycle.
- R9: When a frame completes in the same cycle as a clear command, the filled-bank register ends valid with the new bank number.
- R10: Status (CSR address 0) reads bit 0 filled valid, bit 1 filled bank, bit 2 overflow, bit 3 producer bank, bits 5:4 held per bank, bits 7:6 locked per bank, other bits 0; command address reads 0 and CSR writes to addresses other than 1 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prd_we | input | 1 | Producer word valid |
| prd_wdata | input | 32 | Producer word |
| prd_eof | input | 1 | End of frame strobe |
| prd_bank | output | 1 | Bank the producer is writing |
| throttle | output | 1 | Target bank still held, slow the frame rate |
| rd_en | input | 1 | Consumer read enable |
| rd_bank | input | 1 | Consumer read bank |
| rd_addr | input | AW | Consumer word address |
| rd_data | output | 32 | Read word, one cycle after rd_en |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register address |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Level interrupt, filled bank waiting |

## Verification
The bench builds the block with BANK_WORDS set to 16, so a bank reaches capacity after sixteen writes and the capacity-driven completion, the both-banks-held throttle and the dropped-write overflow occur many times within a short random run. Directed steps cover empty frames, release of an unlocked bank, lock without a valid filled bank and a completion coinciding with a clear, while the random phase mixes producer traffic with arbitrary command bits against a reference model.

// File: rtl/feat_pp_pkg.sv
package feat_pp_pkg;

    localparam int WORD_W = 32;

    localparam logic [1:0] CSR_STATUS = 2'd0;
    localparam logic [1:0] CSR_CMD    = 2'd1;
    localparam logic [1:0] CSR_FILL0  = 2'd2;
    localparam logic [1:0] CSR_FILL1  = 2'd3;

    // command bits, bit 0 is the last member
    typedef struct packed {
        logic clr_ovf;   // bit 4
        logic rel_bank;  // bit 3
        logic release_b; // bit 2
        logic clear_id;  // bit 1
        logic lock;      // bit 0
    } fb_cmd_t;

    typedef struct packed {
        logic valid;
        logic id;
    } filled_t;

    function automatic fb_cmd_t decode_cmd(input logic [4:0] w);
        return fb_cmd_t'(w);
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(
        input filled_t    f,
        input logic       ovf,
        input logic       wbank,
        input logic [1:0] held,
        input logic [1:0] locked
    );
        logic [WORD_W-1:0] s;
        s      = '0;
        s[0]   = f.valid;
        s[1]   = f.id;
        s[2]   = ovf;
        s[3]   = wbank;
        s[5:4] = held;
        s[7:6] = locked;
        return s;
    endfunction

endpackage

// File: rtl/fb_mem.sv
module fb_mem #(
    parameter int BANK_WORDS = 1024,
    parameter int DATA_W     = 32,
    localparam int AW        = $clog2(BANK_WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              wbank,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic              rbank,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic sel_q;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [DATA_W-1:0] cells [BANK_WORDS];
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (we && wbank == 1'(b)) cells[waddr] <= wdata;
            if (re) q <= cells[raddr];
        end
    end

    always_ff @(posedge clk) begin
        if (re) sel_q <= rbank;
    end

    assign rdata = sel_q ? g_bank[1].q : g_bank[0].q;
endmodule

// File: rtl/fb_bank_state.sv
module fb_bank_state #(
    parameter int BANK_WORDS = 1024,
    localparam int CW        = $clog2(BANK_WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          complete,
    input  logic          wr_inc,
    input  logic          lock_req,
    input  logic          release_req,
    output logic          held,
    output logic          locked,
    output logic [CW-1:0] fill
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held   <= 1'b0;
            locked <= 1'b0;
            fill   <= '0;
        end else begin
            if (wr_inc)             fill   <= fill + CW'(1);
            if (complete)           held   <= 1'b1;
            if (lock_req && held)   locked <= 1'b1;
            if (release_req && locked) begin
                held   <= 1'b0;
                locked <= 1'b0;
                fill   <= '0;
            end
        end
    end
endmodule

// File: rtl/feat_pingpong_ctrl.sv
module feat_pingpong_ctrl
    import feat_pp_pkg::*;
#(
    parameter int BANK_WORDS = 1024,
    localparam int AW        = $clog2(BANK_WORDS),
    localparam int CW        = $clog2(BANK_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prd_we,
    input  logic [WORD_W-1:0] prd_wdata,
    input  logic              prd_eof,
    output logic              prd_bank,
    output logic              throttle,
    input  logic              rd_en,
    input  logic              rd_bank,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              csr_we,
    input  logic [1:0]        csr_addr,
    input  logic [WORD_W-1:0] csr_wdata,
    output logic [WORD_W-1:0] csr_rdata,
    output logic              irq
);
    logic               wr_bank_q;
    filled_t            filled_q;
    logic               ovf_q;
    logic [1:0]         held;
    logic [1:0]         locked;
    logic [1:0][CW-1:0] fill;

    logic               tgt_free;
    logic [CW-1:0]      tgt_fill;
    logic               accept;
    logic               done;
    logic               cmd_go;
    fb_cmd_t            cmd;
    logic               unused_wdata;

    assign tgt_free = ~held[wr_bank_q];
    assign tgt_fill = fill[wr_bank_q];
    assign accept   = prd_we & tgt_free;
    assign done     = tgt_free & (prd_eof | (prd_we & (tgt_fill == CW'(BANK_WORDS - 1))));
    assign cmd      = decode_cmd(csr_wdata[4:0]);
    assign cmd_go   = csr_we && (csr_addr == CSR_CMD);
    assign unused_wdata = ^csr_wdata[WORD_W-1:5];

    for (genvar b = 0; b < 2; b++) begin : g_state
        fb_bank_state #(.BANK_WORDS(BANK_WORDS)) u_state (
            .clk         (clk),
            .rst         (rst),
            .complete    (done && wr_bank_q == 1'(b)),
            .wr_inc      (accept && wr_bank_q == 1'(b)),
            .lock_req    (cmd_go && cmd.lock && filled_q.valid && filled_q.id == 1'(b)),
            .release_req (cmd_go && cmd.release_b && cmd.rel_bank == 1'(b)),
            .held        (held[b]),
            .locked      (locked[b]),
            .fill        (fill[b])
        );
    end

    fb_mem #(.BANK_WORDS(BANK_WORDS), .DATA_W(WORD_W)) u_mem (
        .clk   (clk),
        .we    (accept),
        .wbank (wr_bank_q),
        .waddr (tgt_fill[AW-1:0]),
        .wdata (prd_wdata),
        .re    (rd_en),
        .rbank (rd_bank),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_bank_q <= 1'b0;
            filled_q  <= '0;
            ovf_q     <= 1'b0;
        end else begin
            if (done) begin
                wr_bank_q      <= ~wr_bank_q;
                filled_q.valid <= 1'b1;
                filled_q.id    <= wr_bank_q;
            end else if (cmd_go && cmd.clear_id) begin
                filled_q.valid <= 1'b0;
            end
            if (prd_we && !tgt_free)          ovf_q <= 1'b1;
            else if (cmd_go && cmd.clr_ovf)   ovf_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (csr_addr)
            CSR_STATUS: csr_rdata = pack_status(filled_q, ovf_q, wr_bank_q, held, locked);
            CSR_FILL0:  csr_rdata = WORD_W'({fill[0], 2'b00});
            CSR_FILL1:  csr_rdata = WORD_W'({fill[1], 2'b00});
            default:    csr_rdata = '0;
        endcase
    end

    assign irq      = filled_q.valid;
    assign throttle = ~tgt_free;
    assign prd_bank = wr_bank_q;
endmodule

// File: rtl/feat_pingpong_checker.sv
module feat_pingpong_checker #(
    parameter int BANK_WORDS = 1024,
    localparam int CW        = $clog2(BANK_WORDS + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               done,
    input logic               wr_bank,
    input logic               irq,
    input logic               ovf,
    input logic               clr_ovf,
    input logic [1:0]         held,
    input logic [1:0]         locked,
    input logic [1:0][CW-1:0] fill
);
    p_swap_on_done_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> wr_bank != $past(wr_bank));

    p_irq_after_done_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> irq);

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr_ovf) |=> ovf);

    p_lock_only_held_r6: assert property (@(posedge clk) disable iff (rst)
        (locked & ~held) == 2'b00);

    p_fill_cap_r5: assert property (@(posedge clk) disable iff (rst)
        (fill[0] <= CW'(BANK_WORDS)) && (fill[1] <= CW'(BANK_WORDS)));

    p_release_frees_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(locked[0]) |-> !held[0] && fill[0] == '0);
endmodule

bind feat_pingpong_ctrl feat_pingpong_checker #(.BANK_WORDS(BANK_WORDS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .done    (done),
    .wr_bank (wr_bank_q),
    .irq     (irq),
    .ovf     (ovf_q),
    .clr_ovf (cmd_go && cmd.clr_ovf),
    .held    (held),
    .locked  (locked),
    .fill    (fill)
);

// File: tb/feat_pingpong_ctrl_bench.sv
module feat_pingpong_ctrl_bench;
    localparam int BW = 16;
    localparam int AW = $clog2(BW);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prd_we = 1'b0, prd_eof = 1'b0;
    logic [31:0] prd_wdata = '0;
    logic        prd_bank, throttle, irq;
    logic        rd_en = 1'b0, rd_bank = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        csr_we = 1'b0;
    logic [1:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;

    int total = 0, bad = 0;
    bit finished = 0;

    // reference model state
    logic [31:0] m_mem [2][BW];
    bit          m_vld [2][BW];
    int          m_fill [2];
    bit          m_held [2];
    bit          m_lock [2];
    bit          m_wb, m_valid, m_id, m_ovf;

    always #5 clk = ~clk;

    feat_pingpong_ctrl #(.BANK_WORDS(BW)) u_feat_pingpong_ctrl (
        .clk(clk), .rst(rst), .prd_we(prd_we), .prd_wdata(prd_wdata), .prd_eof(prd_eof),
        .prd_bank(prd_bank), .throttle(throttle), .rd_en(rd_en), .rd_bank(rd_bank),
        .rd_addr(rd_addr), .rd_data(rd_data), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq)
    );

    function automatic logic [31:0] exp_status();
        logic [31:0] s = '0;
        s[0] = m_valid; s[1] = m_id; s[2] = m_ovf; s[3] = m_wb;
        s[4] = m_held[0]; s[5] = m_held[1]; s[6] = m_lock[0]; s[7] = m_lock[1];
        return s;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic model_update(bit we, logic [31:0] d, bit eof, bit cwe, logic [1:0] ca, logic [31:0] cd);
        bit tgt = m_wb;
        bit free = !m_held[tgt];
        int f = m_fill[tgt];
        bit go = cwe && ca == 2'd1;
        bit done = free && (eof || (we && f == BW - 1));
        bit lock_ok = go && cd[0] && m_valid && m_held[m_id];
        bit lid = m_id;
        bit rb = cd[3];
        bit rel_ok = go && cd[2] && m_lock[rb];
        if (we && free) begin m_mem[tgt][f] = d; m_vld[tgt][f] = 1; m_fill[tgt] = f + 1; end
        if (we && !free) m_ovf = 1; else if (go && cd[4]) m_ovf = 0;
        if (lock_ok) m_lock[lid] = 1;
        if (rel_ok) begin m_lock[rb] = 0; m_held[rb] = 0; m_fill[rb] = 0; end
        if (go && cd[1]) m_valid = 0;
        if (done) begin m_held[tgt] = 1; m_valid = 1; m_id = tgt; m_wb = !tgt; end
    endtask

    // one clock: drive at negedge, model after edge, idle at next negedge
    task automatic step(bit we, logic [31:0] d, bit eof, bit cwe, logic [1:0] ca, logic [31:0] cd);
        prd_we = we; prd_wdata = d; prd_eof = eof;
        csr_we = cwe; csr_addr = ca; csr_wdata = cd;
        @(posedge clk);
        #1 model_update(we, d, eof, cwe, ca, cd);
        @(negedge clk);
        prd_we = 0; prd_eof = 0; csr_we = 0; csr_addr = 0; csr_wdata = '0;
    endtask

    task automatic cmd(logic [31:0] cd);
        step(0, '0, 0, 1, 2'd1, cd);
    endtask

    task automatic check_state(string tag);
        csr_addr = 2'd0; #1 chk({tag, " R10 status"}, csr_rdata, exp_status());
        chk({tag, " R4 irq"}, {31'd0, irq}, {31'd0, m_valid});
        chk({tag, " R8 throttle"}, {31'd0, throttle}, {31'd0, m_held[m_wb]});
        chk({tag, " R3 prd_bank"}, {31'd0, prd_bank}, {31'd0, m_wb});
        csr_addr = 2'd2; #1 chk({tag, " R5 fill0"}, csr_rdata, 32'(m_fill[0] * 4));
        csr_addr = 2'd3; #1 chk({tag, " R5 fill1"}, csr_rdata, 32'(m_fill[1] * 4));
        csr_addr = 2'd1; #1 chk({tag, " R10 cmd reads 0"}, csr_rdata, 32'd0);
        csr_addr = 2'd0;
    endtask

    task automatic rd_check(bit b, int a);
        rd_en = 1; rd_bank = b; rd_addr = AW'(a);
        @(posedge clk);
        #1 chk("R2 read", rd_data, m_mem[b][a]);
        @(negedge clk);
        rd_en = 0;
    endtask

    initial begin
        #1ms;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int b = 0; b < 2; b++) begin
            m_fill[b] = 0; m_held[b] = 0; m_lock[b] = 0;
            for (int a = 0; a < BW; a++) m_vld[b][a] = 0;
        end
        m_wb = 0; m_valid = 0; m_id = 0; m_ovf = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        check_state("R1 reset");

        // R3: three words, eof with the last
        step(1, 32'hA000_0001, 0, 0, 0, 0);
        step(1, 32'hA000_0002, 0, 0, 0, 0);
        step(1, 32'hA000_0003, 1, 0, 0, 0);
        check_state("R3 eof frame");
        for (int a = 0; a < 3; a++) rd_check(0, a);

        // R6/R4: lock and clear together
        cmd(32'h3);
        check_state("R6 lock+clear");
        // R6: lock with no valid filled bank is ignored
        cmd(32'h1);
        check_state("R6 lock invalid");
        // R7: release of unlocked bank 1 is ignored
        cmd(32'hC);
        check_state("R7 release unlocked");
        // R10: write to fill address ignored
        step(0, '0, 0, 1, 2'd2, 32'hFFFF_FFFF);
        check_state("R10 ignored write");

        // R3: bank 1 completes at capacity; bank 0 still held so R8 throttle
        for (int i = 0; i < BW; i++) step(1, 32'hB000_0000 + 32'(i), 0, 0, 0, 0);
        check_state("R3 capacity");
        rd_check(1, BW - 1);

        // R8: dropped write sets overflow
        step(1, 32'hDEAD_BEEF, 0, 0, 0, 0);
        check_state("R8 drop");
        // R8: set wins over clear in same cycle
        step(1, 32'hDEAD_BEEF, 0, 1, 2'd1, 32'h10);
        check_state("R8 set beats clear");

        // R7: release bank 0
        cmd(32'h4);
        check_state("R7 release");
        cmd(32'h10);
        check_state("R8 w1c");

        // R9: lock bank 1, then empty frame completes with clear in same cycle
        cmd(32'h1);
        check_state("R6 lock bank1");
        step(0, '0, 1, 1, 2'd1, 32'h2);
        check_state("R9 done beats clear");
        cmd(32'hC);
        check_state("R7 release bank1");
        cmd(32'h3);
        cmd(32'h4);
        check_state("R7 release bank0");

        // random phase
        for (int n = 0; n < 800; n++) begin
            int r = int'($urandom % 12);
            if (r < 7)
                step(1, $urandom, ($urandom % 6) == 0, 0, 0, 0);
            else if (r == 7)
                step(0, '0, 1, 0, 0, 0);
            else
                step(0, '0, 0, 1, (r == 11) ? 2'($urandom) : 2'd1, $urandom & 32'h1F);
            check_state("random");
            if ((n % 4) == 0) begin
                bit b = 1'($urandom);
                int a = int'($urandom % BW);
                if (m_vld[b][a]) rd_check(b, a);
            end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule